// File: doc/BRIEF.md
# Destination Address Filter with Group Hash

This block sits on the receive side of an Ethernet MAC and decides, frame by frame, whether to keep a frame based on its six-byte destination address. The address bytes arrive one per valid cycle, first byte flagged, and a serial reflected CRC-32 is folded over them as they pass. One cycle after the sixth byte the block issues a one-cycle decision strobe with an accept bit.

Three sources can accept a frame. A 512-bucket, one-bit-per-bucket hash table covers group (multicast) addresses. A 48-bit station address covers exact unicast matches. The all-ones broadcast address is always kept. A promiscuous mode bit overrides all three. Software reaches the block through a plain write port. A select code picks one of four words: the bucket control word, the two station address words, or the mode word. Each write to the bucket control word sets or clears exactly one bucket, so accepting every multicast address takes 512 writes.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset every bucket is clear, the station address is zero, promiscuous mode is off and no decision strobe is issued; a group address whose bucket was never written is rejected.
- R2: A write with select 0 stores data bit 9 into the bucket numbered by data bits [8:0]; bit 9 set marks the bucket, clear unmarks it; other buckets keep their value.
- R3: The bucket of an address is found by running the reflected CRC-32 (polynomial 0xEDB88320, start value all ones, no final inversion) over the six bytes in arrival order; bucket index bit k equals CRC bit 8-k.
- R4: A group address (bit 0 of the first byte set) that is not broadcast is accepted exactly when its bucket is marked.
- R5: A unicast address (bit 0 of the first byte clear) never uses the hash table; it is accepted only when all 48 bits equal the station address.
- R6: A write with select 1 loads station bytes 0 to 3, byte 0 in data [7:0] and byte 3 in data [31:24]; select 2 loads bytes 4 and 5 from data [7:0] and [15:8]; byte 0 is the first byte received.
- R7: The broadcast address (all six bytes 0xFF) is accepted whatever the table holds.
- R8: A write with select 3 sets promiscuous mode from data bit 0; while it is set every frame is accepted.
- R9: The decision strobe is high for exactly one cycle, in the cycle after the clock edge that takes the sixth byte; idle cycles between bytes are allowed, and bytes after the sixth are ignored until the next first-byte flag.
- R10: Writing all 512 bucket indices with bit 9 set accepts every group address; writing them all with bit 9 clear rejects every group address that is not broadcast again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 2 | Register select: 0 bucket control, 1 station low, 2 station high, 3 mode |
| cfgData | input | 32 | Register write data |
| addrValid | input | 1 | Destination address byte valid |
| addrFirst | input | 1 | Marks the first address byte of a frame |
| addrByte | input | 8 | Destination address byte |
| decValid | output | 1 | One-cycle decision strobe |
| decAccept | output | 1 | Accept bit, meaningful while decValid is high |

## Verification
The assertions watch on every cycle that a bucket write lands in the addressed bucket, that the decision strobe never lasts two cycles, that the byte index stays inside the address, and that promiscuous mode and the broadcast address always accept while an unmatched unicast address is always rejected. Only the bench's scenarios can show that the CRC fold picks the right bucket for a given address, that the station words land in the right byte order, and that the all-multicast sweep and its removal change the outcome for arbitrary group addresses. Random traffic mixing bucket writes with group, unicast, station and broadcast frames, with idle gaps between bytes, is compared against a bench model of the table and the CRC.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;

  localparam int IDX_W = 3;

  typedef struct packed {
    logic             load;
    logic             first;
    logic             last;
    logic [IDX_W-1:0] idx;
  } filtStrobes_t;

  localparam logic [1:0] SEL_BUCKET = 2'd0;
  localparam logic [1:0] SEL_STA_LO = 2'd1;
  localparam logic [1:0] SEL_STA_HI = 2'd2;
  localparam logic [1:0] SEL_MODE   = 2'd3;

  // One byte of the reflected CRC-32, least significant bit first
  function automatic logic [31:0] crcFoldByte(input logic [31:0] crcIn,
                                              input logic [7:0]  dataIn);
    logic [31:0] c;
    c = crcIn ^ {24'd0, dataIn};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/filt_ctrl.sv
module filt_ctrl
  import addr_filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         addrValid,
  input  logic         addrFirst,
  output filtStrobes_t strb
);
  localparam int CNT_W = IDX_W;
  localparam logic [CNT_W-1:0] IDLE_CNT = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] byteCnt;

  always_comb begin
    strb = '0;
    if (addrValid) begin
      if (addrFirst) begin
        strb.load  = 1'b1;
        strb.first = 1'b1;
        strb.idx   = '0;
        strb.last  = (LAST_IDX == '0);
      end else if (byteCnt < IDLE_CNT) begin
        strb.load = 1'b1;
        strb.idx  = byteCnt;
        strb.last = (byteCnt == LAST_IDX);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= IDLE_CNT;
    end else if (strb.load) begin
      byteCnt <= strb.idx + CNT_W'(1);
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> (strb.idx < IDLE_CNT)); // R9
  AST_LAST_MEANS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.last |-> (strb.load && strb.idx == LAST_IDX)); // R9

endmodule

// File: rtl/filt_datapath.sv
module filt_datapath
  import addr_filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 9,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  filtStrobes_t      strb,
  input  logic [7:0]        addrByte,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgData,
  output logic              decValid,
  output logic              decAccept
);
  localparam int BUCKETS = 1 << HASH_BITS;
  localparam int ADDR_W  = 8 * ADDR_BYTES;
  localparam int LO_W    = 32;
  localparam int HI_W    = ADDR_W - LO_W;

  logic [BUCKETS-1:0]      hashTbl;
  logic [ADDR_W-1:0]       stationAddr;
  logic                    promiscEn;
  logic [31:0]             crcReg;
  logic [31:0]             crcNext;
  logic [ADDR_BYTES-2:0][7:0] capBytes;
  logic [ADDR_W-1:0]       lastAddr;
  logic [HASH_BITS-1:0]    bucketIdx;
  logic                    isGroup, isBcast, stationHit, hashHit, acceptNext;

  // Serial CRC, seeded with all ones on the first byte
  assign crcNext = crcFoldByte(strb.first ? 32'hFFFF_FFFF : crcReg, addrByte);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) crcReg <= '0;
    else if (strb.load) crcReg <= crcNext;
  end

  // Bucket index: top bits of the bit-reversed CRC
  genvar k;
  generate
    for (k = 0; k < HASH_BITS; k++) begin : g_idx
      assign bucketIdx[k] = crcNext[HASH_BITS-1-k];
    end
  endgenerate

  // Capture all but the final address byte
  genvar i;
  generate
    for (i = 0; i < ADDR_BYTES - 1; i++) begin : g_cap
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) capBytes[i] <= '0;
        else if (strb.load && strb.idx == IDX_W'(i)) capBytes[i] <= addrByte;
      end
      assign lastAddr[8*i +: 8] = capBytes[i];
    end
  endgenerate
  assign lastAddr[ADDR_W-1 -: 8] = addrByte;

  // Register writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hashTbl     <= '0;
      stationAddr <= '0;
      promiscEn   <= 1'b0;
    end else if (cfgWe) begin
      case (cfgSel)
        SEL_BUCKET: hashTbl[cfgData[HASH_BITS-1:0]] <= cfgData[HASH_BITS];
        SEL_STA_LO: stationAddr[LO_W-1:0]           <= cfgData[LO_W-1:0];
        SEL_STA_HI: stationAddr[ADDR_W-1:LO_W]      <= cfgData[HI_W-1:0];
        default:    promiscEn                       <= cfgData[0];
      endcase
    end
  end

  // Decision
  assign isGroup    = lastAddr[0];
  assign isBcast    = &lastAddr;
  assign stationHit = (lastAddr == stationAddr);
  assign hashHit    = hashTbl[bucketIdx];
  assign acceptNext = promiscEn | isBcast | (isGroup ? hashHit : stationHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decValid  <= 1'b0;
      decAccept <= 1'b0;
    end else begin
      decValid  <= strb.last;
      decAccept <= strb.last & acceptNext;
    end
  end

  AST_BUCKET_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgSel == SEL_BUCKET) |=>
      (hashTbl[$past(cfgData[HASH_BITS-1:0])] == $past(cfgData[HASH_BITS]))); // R2
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    decValid |=> !decValid); // R9
  AST_PROMISC_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.last && promiscEn) |=> (decValid && decAccept)); // R8
  AST_BCAST_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.last && isBcast) |=> (decValid && decAccept)); // R7
  AST_UNICAST_NO_HASH: assert property (@(posedge clk) disable iff (!rstN)
    (strb.last && !isGroup && !promiscEn && !stationHit) |=> !decAccept); // R5

endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
  import addr_filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 9,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              addrValid,
  input  logic              addrFirst,
  input  logic [7:0]        addrByte,
  output logic              decValid,
  output logic              decAccept
);
  filtStrobes_t strb;

  filt_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .addrValid (addrValid),
    .addrFirst (addrFirst),
    .strb      (strb)
  );

  filt_datapath #(
    .ADDR_BYTES (ADDR_BYTES),
    .HASH_BITS  (HASH_BITS),
    .DATA_W     (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .addrByte  (addrByte),
    .cfgWe     (cfgWe),
    .cfgSel    (cfgSel),
    .cfgData   (cfgData),
    .decValid  (decValid),
    .decAccept (decAccept)
  );

endmodule

// File: tb/tb_dst_addr_filter.sv
`timescale 1ns/1ps
module tb_dst_addr_filter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [31:0] cfgData = '0;
  logic        addrValid = 1'b0;
  logic        addrFirst = 1'b0;
  logic [7:0]  addrByte = '0;
  logic        decValid, decAccept;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [511:0] mTbl = '0;
  logic [47:0]  mSta = '0;
  logic         mProm = 1'b0;

  always #2.5 clk = ~clk;

  dst_addr_filter dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .addrValid(addrValid), .addrFirst(addrFirst), .addrByte(addrByte),
    .decValid(decValid), .decAccept(decAccept)
  );

  function automatic logic [8:0] refBucket(input logic [47:0] a);
    logic [31:0] c;
    logic [8:0] r;
    c = 32'hFFFF_FFFF;
    for (int n = 0; n < 6; n++) begin
      c = c ^ {24'd0, a[8*n +: 8]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    for (int k = 0; k < 9; k++) r[k] = c[8-k];
    return r;
  endfunction

  function automatic logic refAccept(input logic [47:0] a);
    if (mProm) return 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) return 1'b1;
    if (a[0]) return mTbl[refBucket(a)];
    return a == mSta;
  endfunction

  task automatic check(input logic cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
    case (sel)
      2'd0: mTbl[d[8:0]] = d[9];
      2'd1: mSta[31:0] = d;
      2'd2: mSta[47:32] = d[15:0];
      default: mProm = d[0];
    endcase
  endtask

  task automatic setBucket(input logic [8:0] idx, input logic v);
    cfgWrite(2'd0, {22'd0, v, idx});
  endtask

  // Sends an address; checks strobe and accept, then the strobe's end
  task automatic sendFrame(input logic [47:0] a, input int maxGap, input int extra,
                           input string req);
    logic exp;
    exp = refAccept(a);
    for (int n = 0; n < 6; n++) begin
      int gap;
      gap = (maxGap > 0) ? int'($urandom_range(maxGap)) : 0;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        addrValid = 1'b0;
      end
      @(negedge clk);
      addrValid = 1'b1; addrFirst = (n == 0); addrByte = a[8*n +: 8];
    end
    @(negedge clk);
    check(decValid == 1'b1, "R9 strobe", int'(decValid), 1);
    check(decAccept == exp, req, int'(decAccept), int'(exp));
    if (extra > 0) begin
      addrValid = 1'b1; addrFirst = 1'b0; addrByte = 8'hFF;
      for (int e = 0; e < extra; e++) begin
        @(negedge clk);
        check(decValid == 1'b0, "R9 trailing bytes", int'(decValid), 0);
      end
    end
    addrValid = 1'b0;
    @(negedge clk);
    check(decValid == 1'b0, "R9 one cycle", int'(decValid), 0);
  endtask

  function automatic logic [47:0] randAddr(input logic grp);
    logic [47:0] a;
    a = {$urandom(), $urandom()};
    a[0] = grp;
    return a;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [47:0] a, b;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(decValid == 1'b0, "R1 reset strobe", int'(decValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(decValid == 1'b0, "R1 idle after reset", int'(decValid), 0);

    // R1: empty table rejects group address
    a = 48'h0000_5E00_0001 | 48'h1;
    sendFrame(a, 0, 0, "R1 empty table rejects");

    // R2/R3/R4: mark the bucket from the model CRC, then clear it
    setBucket(refBucket(a), 1'b1);
    sendFrame(a, 0, 0, "R3 bucket hit");
    check(decAccept == 1'b0, "R4 accept low after strobe", int'(decAccept), 0);
    setBucket(refBucket(a), 1'b0);
    sendFrame(a, 2, 0, "R2 bucket cleared");
    // neighbouring bucket must not affect it
    setBucket(refBucket(a) ^ 9'h001, 1'b1);
    sendFrame(a, 0, 0, "R2 neighbour bucket");
    setBucket(refBucket(a) ^ 9'h100, 1'b1);
    sendFrame(a, 0, 0, "R3 top index bit");

    // R5: unicast with its hash bucket marked is still rejected
    b = randAddr(1'b0);
    setBucket(refBucket(b), 1'b1);
    sendFrame(b, 0, 0, "R5 unicast ignores hash");

    // R6: station address byte order
    b = 48'h5544_3322_1100 | 48'h0000_0000_0002;
    cfgWrite(2'd1, b[31:0]);
    cfgWrite(2'd2, {16'd0, b[47:32]});
    sendFrame(b, 1, 0, "R6 station match");
    sendFrame({b[7:0], b[15:8], b[23:16], b[31:24], b[39:32], b[47:40]}, 0, 0,
              "R6 reversed order rejects");
    sendFrame(b ^ 48'h8000_0000_0000, 0, 0, "R5 last bit differs");

    // R7: broadcast with empty-ish table
    setBucket(refBucket(48'hFFFF_FFFF_FFFF), 1'b0);
    sendFrame(48'hFFFF_FFFF_FFFF, 0, 0, "R7 broadcast");

    // R9: trailing bytes after sixth ignored
    sendFrame(b, 0, 3, "R9 frame with trailer");

    // R8: promiscuous
    cfgWrite(2'd3, 32'h1);
    sendFrame(randAddr(1'b0), 0, 0, "R8 promisc unicast");
    sendFrame(randAddr(1'b1), 0, 0, "R8 promisc group");
    cfgWrite(2'd3, 32'h0);
    sendFrame(randAddr(1'b0) ^ 48'h4, 0, 0, "R8 promisc off");

    // R10: all-multicast sweep and removal
    for (int n = 0; n < 512; n++) setBucket(9'(n), 1'b1);
    for (int n = 0; n < 8; n++) sendFrame(randAddr(1'b1), 1, 0, "R10 all multicast");
    for (int n = 0; n < 512; n++) setBucket(9'(n), 1'b0);
    for (int n = 0; n < 8; n++) sendFrame(randAddr(1'b1), 1, 0, "R10 all removed");

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom_range(9));
      if (op < 3) begin
        setBucket(9'($urandom()), 1'($urandom()));
      end else if (op == 3) begin
        sendFrame(mSta, 2, 0, "R6 random station");
      end else if (op == 4) begin
        sendFrame(48'hFFFF_FFFF_FFFF, 1, int'($urandom_range(2)), "R7 random broadcast");
      end else if (op < 8) begin
        a = randAddr(1'b1);
        if ($urandom_range(1) == 1) setBucket(refBucket(a), 1'b1);
        sendFrame(a, 2, 0, "R4 random group");
      end else begin
        sendFrame(randAddr(1'b0), 2, int'($urandom_range(2)), "R5 random unicast");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule